// File: doc/BRIEF.md
# Priority Interrupt Request Controller

This block collects interrupt requests from a set of level-sensitive device lines and presents one of them at a time to a processor. Each line's raised level is brought into the clock domain, held in a per-line pending latch, filtered by a per-line disable mask, and then arbitrated. The lowest-numbered eligible line wins.

The winning line number is added to a programmable base to form an 8-bit vector. That vector is stored in a readable register before the single interrupt output is raised. The output then stays high, and the vector stays fixed, until software writes the acknowledge address. That write clears the pending latch of the served line and reopens arbitration.

A line that is disabled keeps its request pending, and the request is delivered as soon as the line is enabled again. Software reaches the vector, acknowledge, mask and base through a small word-wide register port with combinational read data.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several enabled lines are pending in the same cycle, the vector produced is the one for the lowest-numbered line.
- R2: The vector equals the value at address 3 (base, read/write, reset value 32) plus the line number. For example, line n gives 32+n after reset.
- R3: The vector is readable at address 0 one clock before `intr_o` rises. `intr_o` rises on the clock edge after the vector register is loaded.
- R4: `intr_o` stays high until a write to address 1 (acknowledge, any data). It is low from the edge of that write onward. A write to address 1 while `intr_o` is low has no effect.
- R5: Address 2 holds the mask, read/write, reset value 0. Bit n set to 1 disables line n. A disabled line never raises `intr_o`.
- R6: A request that arrives while its line is disabled stays latched, even if the request drops. It is delivered once its mask bit is cleared.
- R7: A line's pending latch is cleared only when that line's interrupt is acknowledged. If the line is still high at the acknowledge, it is latched again and served again.
- R8: While `intr_o` is high, the vector register does not change, even when a higher-priority request arrives.
- R9: Request inputs pass a two-stage synchronizer. A line that is raised before clock edge 1 loads the vector at edge 4 and raises `intr_o` at edge 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 8 | Asynchronous level-sensitive request lines, bit n is line n |
| reg_addr_i | input | 2 | Register address: 0 vector, 1 acknowledge, 2 mask, 3 base |
| reg_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| intr_o | output | 1 | Interrupt to the processor |

## Verification
The hardest case is a higher-priority line that rises while a lower-priority interrupt is waiting for its acknowledge. The vector must stay unchanged, and the new line must be served only afterwards. The stimulus first lets line 6 raise the interrupt, then raises line 1, and holds both for many cycles before acknowledging. A second hard case is a masked pulse that has already fallen when the line is enabled again. The bench pulses a masked line, issues an acknowledge while idle, and then clears the mask to show that the latched request still arrives.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned REG_ADDR_W = 2;
   localparam logic [REG_ADDR_W-1:0] ADDR_VEC  = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADDR_ACK  = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADDR_BASE = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_POST = 2'd1,
      ST_WAIT = 2'd2
   } irq_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int unsigned LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] set_i,
   input  logic [LINES-1:0] clr_i,
   output logic [LINES-1:0] pend_o
);
   logic [LINES-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pend_o = pend_q;

   AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i))); // R6 R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned LINES = 8,
   localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic [LINES-1:0] elig_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (elig_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign hit_o = |elig_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BASE_RST    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_LINES-1:0]    irq_req_i,
   input  logic [REG_ADDR_W-1:0] reg_addr_i,
   input  logic                  reg_wr_i,
   input  logic [VEC_W-1:0]      reg_wdata_i,
   output logic [VEC_W-1:0]      reg_rdata_o,
   output logic                  intr_o
);
   localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

   if (N_LINES < 2 || N_LINES > VEC_W) begin : g_bad_lines
      $error("irq_prio_ctrl: N_LINES must be in 2..VEC_W");
   end
   if (BASE_RST >= (1 << VEC_W)) begin : g_bad_base
      $error("irq_prio_ctrl: BASE_RST does not fit VEC_W");
   end

   logic [N_LINES-1:0] req_s, pend, elig, ack_clr, sel_oh;
   logic [N_LINES-1:0] mask_q;
   logic [VEC_W-1:0]   base_q, vec_q;
   logic [IDX_W-1:0]   win_idx, sel_q;
   logic               win_hit, ack_wr;
   irq_state_e         state_q;

   irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(irq_req_i), .sync_o(req_s));

   irq_pending #(.LINES(N_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(req_s), .clr_i(ack_clr), .pend_o(pend));

   assign elig = pend & ~mask_q;

   irq_arbiter #(.LINES(N_LINES)) u_arb (
      .elig_i(elig), .hit_o(win_hit), .idx_o(win_idx));

   assign ack_wr  = reg_wr_i && (reg_addr_i == ADDR_ACK);
   assign sel_oh  = N_LINES'(1) << sel_q;
   assign ack_clr = (state_q == ST_WAIT && ack_wr) ? sel_oh : '0;
   assign intr_o  = (state_q == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         base_q <= VEC_W'(BASE_RST);
      end else if (reg_wr_i) begin
         if (reg_addr_i == ADDR_MASK) mask_q <= reg_wdata_i[N_LINES-1:0];
         if (reg_addr_i == ADDR_BASE) base_q <= reg_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vec_q   <= '0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (win_hit) begin
               vec_q   <= base_q + VEC_W'(win_idx);
               sel_q   <= win_idx;
               state_q <= ST_POST;
            end
            ST_POST: state_q <= ST_WAIT;
            ST_WAIT: if (ack_wr) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (reg_addr_i)
         ADDR_VEC:  reg_rdata_o = vec_q;
         ADDR_MASK: reg_rdata_o = VEC_W'(mask_q);
         ADDR_BASE: reg_rdata_o = base_q;
         default:   reg_rdata_o = '0;
      endcase
   end

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POST) |-> (($past(elig) & (sel_oh - N_LINES'(1))) == '0)); // R1
   AST_VEC_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_o) |-> $stable(vec_q)); // R3
   AST_INTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_o && !ack_wr) |=> intr_o); // R4
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_o && ack_wr) |=> !intr_o); // R4
   AST_MASKED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POST) |-> (($past(mask_q) & sel_oh) == '0)); // R5
   AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |=> $stable(vec_q)); // R8
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       intr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   logic intr_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(req), .reg_addr_i(addr),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .intr_o(intr));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every rising intr must present the next expected vector at address 0
   always @(negedge clk) begin
      if (rst_n && intr && !intr_prev) begin
         if (exp_q.size() == 0) chk(0, "R3 unexpected interrupt", rdata, -1);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rdata == e, "R2 vector on interrupt", rdata, e);
         end
      end
      intr_prev = intr;
   end

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wr = 1'b1; wdata = d;
      @(negedge clk); wr = 1'b0; addr = 2'd0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1 d = rdata; addr = 2'd0;
   endtask

   task automatic wait_intr(input string tag);
      int k = 0;
      while (!intr && k < 100) begin @(negedge clk); k++; end
      chk(intr, tag, intr, 1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      idle(3); rst_n = 1'b1; idle(2);

      // reset state
      chk(intr == 1'b0, "R4 intr low after reset", intr, 0);
      bus_rd(2'd2, d); chk(d == 8'h00, "R5 mask reset", d, 0);
      bus_rd(2'd3, d); chk(d == 8'd32, "R2 base reset", d, 32);

      // R9 latency and R3 vector ahead of intr
      @(negedge clk); req[3] = 1'b1; exp_q.push_back(8'd35);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(intr == 1'b0, "R9 intr still low after 4 edges", intr, 0);
      chk(rdata == 8'd35, "R3 vector loaded before intr", rdata, 35);
      @(negedge clk);
      chk(intr == 1'b1, "R9 intr high after 5 edges", intr, 1);
      req[3] = 1'b0;
      idle(10);
      chk(intr == 1'b1, "R4 intr held without ack", intr, 1);
      chk(rdata == 8'd35, "R8 vector held", rdata, 35);
      bus_wr(2'd1, 8'h00);
      chk(intr == 1'b0, "R4 intr drops on ack", intr, 0);
      idle(4);
      chk(intr == 1'b0, "R7 acked line not served again", intr, 0);

      // R1 lowest index wins, lines 2, 5, 7
      exp_q.push_back(8'd34); exp_q.push_back(8'd37); exp_q.push_back(8'd39);
      @(negedge clk); req = 8'b1010_0100;
      wait_intr("R1 first grant");
      req[2] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      wait_intr("R1 second grant");
      req[5] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      wait_intr("R1 third grant");
      req[7] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      idle(6);
      chk(exp_q.size() == 0, "R1 all grants seen", exp_q.size(), 0);

      // R8 higher priority arrives while waiting
      exp_q.push_back(8'd38); exp_q.push_back(8'd33);
      @(negedge clk); req[6] = 1'b1;
      wait_intr("R8 line 6 grant");
      req[1] = 1'b1; idle(12);
      chk(rdata == 8'd38, "R8 vector frozen against line 1", rdata, 38);
      chk(intr == 1'b1, "R4 still waiting", intr, 1);
      req[6] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      wait_intr("R8 line 1 served after ack");
      req[1] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      idle(6);

      // R5/R6 masked pulse latched, delivered on unmask
      bus_wr(2'd2, 8'h10);
      bus_rd(2'd2, d); chk(d == 8'h10, "R5 mask readback", d, 16);
      @(negedge clk); req[4] = 1'b1; idle(3); req[4] = 1'b0;
      idle(20);
      chk(intr == 1'b0, "R5 masked line silent", intr, 0);
      bus_wr(2'd1, 8'h00);
      exp_q.push_back(8'd36);
      bus_wr(2'd2, 8'h00);
      wait_intr("R6 masked request delivered after unmask");
      bus_wr(2'd1, 8'h00);
      idle(6);

      // R2 programmable base
      bus_wr(2'd3, 8'h80);
      bus_rd(2'd3, d); chk(d == 8'h80, "R2 base readback", d, 128);
      exp_q.push_back(8'h80);
      @(negedge clk); req[0] = 1'b1;
      wait_intr("R2 line 0 with new base");
      req[0] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      idle(6);

      // R7 held line re-fires after ack
      exp_q.push_back(8'h83); exp_q.push_back(8'h83);
      @(negedge clk); req[3] = 1'b1;
      wait_intr("R7 first service");
      bus_wr(2'd1, 8'h00);
      chk(intr == 1'b0, "R7 intr drops on ack", intr, 0);
      wait_intr("R7 re-fire while held");
      req[3] = 1'b0; idle(4); bus_wr(2'd1, 8'h00);
      idle(8);
      chk(intr == 1'b0, "R7 quiet after release", intr, 0);
      chk(exp_q.size() == 0, "R7 all expected vectors seen", exp_q.size(), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule